// File: doc/BRIEF.md
# Rotation-Aligned Burst Block Mover

This block copies one block of sixteen 32-bit words between a requester's local word buffer and a shared memory. That memory is split into sixteen banks, and consecutive word addresses land in consecutive banks. The banks rotate past each requester, one bank per clock. A rotation phase input tells the block which bank sits in its window during the current cycle. The block does not wait for the bank that holds the lowest address of the block. It starts with whatever bank is in the window when the burst begins, and it takes the remaining banks in rotation order, wrapping past the last bank. Every aligned block therefore completes in sixteen back-to-back slots, whatever the phase.

Each word is placed at the local buffer index equal to its bank number. The buffer therefore ends up in address order even though the words move out of address order. A single start strobe launches a transfer and selects its direction. A busy flag covers the sixteen slots, and a one-cycle done pulse follows the last slot.

Top module: `blkx_burst`

## Requirements
- R1: A start_i pulse while idle makes busy_o high from the next cycle for exactly 16 cycles. During those cycles hub_req_o is high.
- R2: In the first busy cycle the hub word address carries, in its low 4 bits, the bank given by rot_phase_i in that cycle. Each following busy cycle takes the next bank in rotation order, wrapping from 15 to 0, so each bank is addressed exactly once per block.
- R3: The low 4 bits of base_addr_i are ignored. Bits above them select the block and stay fixed on hub_addr_o for the whole burst.
- R4: With dir_i = 0 (hub to buffer), the word read in a slot is written to the local buffer one clock later. In that clock lbuf_we_o = 1, lbuf_waddr_o equals the bank of that slot, and lbuf_wdata_o equals hub_rdata_i. No hub write is issued.
- R5: With dir_i = 1 (buffer to hub), lbuf_raddr_o equals the bank of the current slot. hub_we_o = 1 and hub_wdata_o equals lbuf_rdata_i, so the hub block receives the buffer contents in address order. The local buffer is never written.
- R6: done_o is high for exactly one cycle, the cycle after the 16th slot, and busy_o is low in that cycle.
- R7: A start_i pulse while busy_o is high is ignored. Direction, block and completion time of the running burst are unchanged, and no extra burst follows.
- R8: A start_i pulse in the cycle where done_o is high is accepted, and a new burst begins in the next cycle.
- R9: While in reset and in the first cycle after it, busy_o, done_o, hub_req_o, hub_we_o and lbuf_we_o are low.
- R10: For every starting rotation phase 0 through 15, a hub-to-buffer burst leaves the local buffer equal to the 16 words of the selected block, in address order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch strobe, taken only while idle |
| dir_i | input | 1 | 0: hub to buffer, 1: buffer to hub |
| base_addr_i | input | 19 | Hub word address of the block; low 4 bits ignored |
| busy_o | output | 1 | High during the 16 transfer slots |
| done_o | output | 1 | One-cycle completion pulse |
| rot_phase_i | input | 4 | Bank currently in this requester's window |
| hub_req_o | output | 1 | Slot in use this cycle |
| hub_we_o | output | 1 | Slot is a write |
| hub_addr_o | output | 19 | Hub word address of this slot |
| hub_wdata_o | output | 32 | Hub write data |
| hub_rdata_i | input | 32 | Hub read data, one clock after the read slot |
| lbuf_raddr_o | output | 4 | Local buffer read index |
| lbuf_rdata_i | input | 32 | Local buffer read data, same cycle |
| lbuf_we_o | output | 1 | Local buffer write enable |
| lbuf_waddr_o | output | 4 | Local buffer write index |
| lbuf_wdata_o | output | 32 | Local buffer write data |

## Verification
In a hub-to-buffer burst, the last buffer write lands in the done cycle. A new start may arrive in that same cycle. The bench chains two reads back to back, issuing the second start in the cycle of the first done pulse. The scoreboard then requires the last word of the first block and all sixteen words of the second block, in order, with no lost or doubled write. A second overlap pushes a start with the other direction and another block into the middle of a running burst. The bench then requires the original burst to finish unchanged, and no hub write at all.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  parameter int unsigned NUM_BANKS = 16;
  parameter int unsigned DATA_W    = 32;
  parameter int unsigned ADDR_W    = 19;
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS);
  localparam int unsigned BLK_W    = ADDR_W - BANK_W;

  typedef enum logic {
    XFER_HUB2BUF = 1'b0,
    XFER_BUF2HUB = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/blkx_seq.sv
module blkx_seq
  import blkx_pkg::*;
#(
  parameter int unsigned N_BANKS = NUM_BANKS,
  parameter int unsigned A_W     = ADDR_W,
  localparam int unsigned B_W    = $clog2(N_BANKS),
  localparam int unsigned K_W    = A_W - B_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           dir_i,
  input  logic [A_W-1:0] base_addr_i,
  output logic           busy_o,
  output logic           done_o,
  output xfer_dir_e      dir_o,
  output logic [K_W-1:0] blk_o
);
  localparam logic [B_W-1:0] LAST_SLOT = B_W'(N_BANKS - 1);

  logic           busy_q, done_q;
  logic [B_W-1:0] cnt_q;
  xfer_dir_e      dir_q;
  logic [K_W-1:0] blk_q;
  logic           take;

  assign take = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      dir_q  <= XFER_HUB2BUF;
      blk_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        dir_q  <= xfer_dir_e'(dir_i);
        blk_q  <= base_addr_i[A_W-1:B_W];  // low bits dropped: block alignment
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST_SLOT) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign dir_o  = dir_q;
  assign blk_o  = blk_q;

  p_busy_from_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i));

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!busy_q && $past(busy_q)));

  p_start_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> ($stable(blk_q) && $stable(dir_q)));
endmodule

// File: rtl/blkx_slot.sv
module blkx_slot
  import blkx_pkg::*;
#(
  parameter int unsigned N_BANKS = NUM_BANKS,
  parameter int unsigned A_W     = ADDR_W,
  parameter int unsigned D_W     = DATA_W,
  localparam int unsigned B_W    = $clog2(N_BANKS),
  localparam int unsigned K_W    = A_W - B_W
) (
  input  logic           busy_i,
  input  xfer_dir_e      dir_i,
  input  logic [K_W-1:0] blk_i,
  input  logic [B_W-1:0] phase_i,
  input  logic [D_W-1:0] lbuf_rdata_i,
  output logic           hub_req_o,
  output logic           hub_we_o,
  output logic [A_W-1:0] hub_addr_o,
  output logic [D_W-1:0] hub_wdata_o,
  output logic [B_W-1:0] lbuf_raddr_o
);
  // The bank in the window this cycle is both the address low bits and the buffer index
  always_comb begin
    hub_req_o    = busy_i;
    hub_we_o     = busy_i && (dir_i == XFER_BUF2HUB);
    hub_addr_o   = {blk_i, phase_i};
    lbuf_raddr_o = phase_i;
    hub_wdata_o  = hub_we_o ? lbuf_rdata_i : '0;
  end
endmodule

// File: rtl/blkx_rdret.sv
module blkx_rdret
  import blkx_pkg::*;
#(
  parameter int unsigned N_BANKS = NUM_BANKS,
  parameter int unsigned D_W     = DATA_W,
  localparam int unsigned B_W    = $clog2(N_BANKS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           slot_v_i,
  input  logic           slot_we_i,
  input  logic [B_W-1:0] phase_i,
  input  logic [D_W-1:0] hub_rdata_i,
  output logic           lbuf_we_o,
  output logic [B_W-1:0] lbuf_waddr_o,
  output logic [D_W-1:0] lbuf_wdata_o
);
  logic           ret_v_q;
  logic [B_W-1:0] ret_idx_q;

  // Aligns the buffer index to the hub's one-clock read latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ret_v_q   <= 1'b0;
      ret_idx_q <= '0;
    end else begin
      ret_v_q   <= slot_v_i && !slot_we_i;
      ret_idx_q <= phase_i;
    end
  end

  assign lbuf_we_o    = ret_v_q;
  assign lbuf_waddr_o = ret_idx_q;
  assign lbuf_wdata_o = ret_v_q ? hub_rdata_i : '0;

  p_ret_follows_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lbuf_we_o |-> $past(slot_v_i && !slot_we_i));

  p_no_buf_write_on_hub_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(slot_we_i) |-> !lbuf_we_o);
endmodule

// File: rtl/blkx_burst.sv
module blkx_burst
  import blkx_pkg::*;
#(
  parameter int unsigned N_BANKS = NUM_BANKS,
  parameter int unsigned A_W     = ADDR_W,
  parameter int unsigned D_W     = DATA_W,
  localparam int unsigned B_W    = $clog2(N_BANKS),
  localparam int unsigned K_W    = A_W - B_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           dir_i,
  input  logic [A_W-1:0] base_addr_i,
  output logic           busy_o,
  output logic           done_o,
  input  logic [B_W-1:0] rot_phase_i,
  output logic           hub_req_o,
  output logic           hub_we_o,
  output logic [A_W-1:0] hub_addr_o,
  output logic [D_W-1:0] hub_wdata_o,
  input  logic [D_W-1:0] hub_rdata_i,
  output logic [B_W-1:0] lbuf_raddr_o,
  input  logic [D_W-1:0] lbuf_rdata_i,
  output logic           lbuf_we_o,
  output logic [B_W-1:0] lbuf_waddr_o,
  output logic [D_W-1:0] lbuf_wdata_o
);
  xfer_dir_e      dir_w;
  logic [K_W-1:0] blk_w;
  logic           busy_w;

  blkx_seq #(.N_BANKS(N_BANKS), .A_W(A_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .dir_i       (dir_i),
    .base_addr_i (base_addr_i),
    .busy_o      (busy_w),
    .done_o      (done_o),
    .dir_o       (dir_w),
    .blk_o       (blk_w)
  );

  blkx_slot #(.N_BANKS(N_BANKS), .A_W(A_W), .D_W(D_W)) u_slot (
    .busy_i       (busy_w),
    .dir_i        (dir_w),
    .blk_i        (blk_w),
    .phase_i      (rot_phase_i),
    .lbuf_rdata_i (lbuf_rdata_i),
    .hub_req_o    (hub_req_o),
    .hub_we_o     (hub_we_o),
    .hub_addr_o   (hub_addr_o),
    .hub_wdata_o  (hub_wdata_o),
    .lbuf_raddr_o (lbuf_raddr_o)
  );

  blkx_rdret #(.N_BANKS(N_BANKS), .D_W(D_W)) u_rdret (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slot_v_i     (hub_req_o),
    .slot_we_i    (hub_we_o),
    .phase_i      (rot_phase_i),
    .hub_rdata_i  (hub_rdata_i),
    .lbuf_we_o    (lbuf_we_o),
    .lbuf_waddr_o (lbuf_waddr_o),
    .lbuf_wdata_o (lbuf_wdata_o)
  );

  assign busy_o = busy_w;

  p_rotation_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hub_req_o && $past(hub_req_o)) |->
      (hub_addr_o[B_W-1:0] == B_W'($past(hub_addr_o[B_W-1:0]) + 1'b1)));

  p_block_fixed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hub_req_o && $past(hub_req_o)) |-> $stable(hub_addr_o[A_W-1:B_W]));
endmodule

// File: tb/blkx_burst_bench.sv
module blkx_burst_bench;
  typedef struct packed {
    logic [18:0] key;
    logic [31:0] data;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dir = 1'b0;
  logic [18:0] base = '0;
  logic        busy, done, hub_req, hub_we, lbuf_we;
  logic [3:0]  phase = 4'd0;
  logic [18:0] hub_addr;
  logic [31:0] hub_wdata, hub_rdata, lbuf_rdata, lbuf_wdata;
  logic [3:0]  lbuf_raddr, lbuf_waddr;

  logic [31:0] mem [256];
  logic [31:0] lbuf [16];
  exp_t        expq[$];
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  blkx_burst u_blkx_burst (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_i(dir), .base_addr_i(base),
    .busy_o(busy), .done_o(done), .rot_phase_i(phase), .hub_req_o(hub_req),
    .hub_we_o(hub_we), .hub_addr_o(hub_addr), .hub_wdata_o(hub_wdata),
    .hub_rdata_i(hub_rdata), .lbuf_raddr_o(lbuf_raddr), .lbuf_rdata_i(lbuf_rdata),
    .lbuf_we_o(lbuf_we), .lbuf_waddr_o(lbuf_waddr), .lbuf_wdata_o(lbuf_wdata)
  );

  // Hub model: rotating window, registered read
  always @(posedge clk) begin
    phase <= phase + 4'd1;
    if (hub_req && hub_we) mem[hub_addr[7:0]] <= hub_wdata;
    hub_rdata <= (hub_req && !hub_we) ? mem[hub_addr[7:0]] : 32'hx;
  end
  always @(posedge clk) if (lbuf_we) lbuf[lbuf_waddr] <= lbuf_wdata;
  assign lbuf_rdata = lbuf[lbuf_raddr];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: pops expected items as writes appear
  always @(negedge clk) begin
    if (rst_n && (lbuf_we || hub_we)) begin
      exp_t e;
      if (expq.size() == 0) begin
        chk(1'b0, lbuf_we ? "R4 unexpected buffer write" : "R7 unexpected hub write",
            lbuf_we ? lbuf_wdata : hub_wdata, 32'h0);
      end else begin
        e = expq.pop_front();
        if (lbuf_we)
          chk(lbuf_waddr == e.key[3:0] && lbuf_wdata == e.data, "R4 buffer write",
              {lbuf_waddr, lbuf_wdata[27:0]}, {e.key[3:0], e.data[27:0]});
        else
          chk(hub_addr == e.key && hub_wdata == e.data, "R5 hub write",
              {hub_addr[3:0], hub_wdata[27:0]}, {e.key[3:0], e.data[27:0]});
      end
    end
  end

  // Call at a negedge; issues start there. aligned: first slot gets bank p.
  // poke: pushes an ignored start mid-burst. Returns at the done negedge.
  task automatic run(input bit wr, input int p, input logic [18:0] b, input bit aligned, input bit poke);
    int pp;
    if (aligned) while (phase != 4'((p + 15) % 16)) @(negedge clk);
    pp = (int'(phase) + 1) % 16;
    for (int k = 0; k < 16; k++) begin
      exp_t e;
      int bk = (pp + k) % 16;
      e.key  = wr ? {b[18:4], 4'(bk)} : 19'(bk);
      e.data = wr ? lbuf[bk] : mem[{b[7:4], 4'(bk)}];
      expq.push_back(e);
    end
    start = 1'b1; dir = wr; base = b;
    @(negedge clk);
    start = 1'b0;
    chk(busy && hub_req, "R1 busy after start", {31'b0, busy}, 32'd1);
    chk(!done, "R6 done low in first slot", {31'b0, done}, 32'd0);
    chk(hub_addr[3:0] == 4'(pp), "R2 first bank equals window", {28'b0, hub_addr[3:0]}, 32'(pp));
    chk(hub_addr[18:4] == b[18:4], "R3 block from base high bits", 32'(hub_addr[18:4]), 32'(b[18:4]));
    for (int k = 1; k < 16; k++) begin
      if (poke && k == 5) begin
        start = 1'b1; dir = ~wr; base = b ^ 19'h000F0;
      end
      @(negedge clk);
      start = 1'b0; base = b; dir = wr;
      chk(busy && hub_addr[3:0] == 4'((pp + k) % 16) && hub_addr[18:4] == b[18:4],
          poke ? "R7 burst unchanged by start" : "R2 rotation order",
          {27'b0, busy, hub_addr[3:0]}, {27'b1, 4'((pp + k) % 16)});
    end
    @(negedge clk);
    chk(done && !busy, "R6 done after last slot", {30'b0, done, busy}, 32'd2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h9E37_0000 ^ (i * 32'h0101_0F1) ^ (i << 20);
    for (int i = 0; i < 16; i++) lbuf[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !hub_req && !hub_we && !lbuf_we, "R9 reset state",
        {27'b0, busy, done, hub_req, hub_we, lbuf_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !hub_req && !lbuf_we, "R9 after reset",
        {28'b0, busy, done, hub_req, lbuf_we}, 32'd0);

    // R10: every starting phase, low base bits nonzero (R3)
    for (int p = 0; p < 16; p++) begin
      logic [18:0] b = {11'h0A5, 4'(p % 16), 4'(15 - p)};
      bit ok = 1'b1;
      for (int i = 0; i < 16; i++) lbuf[i] = 32'hDEAD_0000;
      run(1'b0, p, b, 1'b1, 1'b0);
      @(negedge clk);
      chk(!done, "R6 done is one cycle", {31'b0, done}, 32'd0);
      for (int i = 0; i < 16; i++) if (lbuf[i] !== mem[{b[7:4], 4'(i)}]) ok = 1'b0;
      chk(ok, "R10 buffer matches block", lbuf[0], mem[{b[7:4], 4'd0}]);
    end

    // R5: buffer to hub, two phases
    for (int p = 3; p < 16; p += 9) begin
      logic [18:0] b = {11'h013, 4'(p), 4'h7};
      bit ok = 1'b1;
      for (int i = 0; i < 16; i++) lbuf[i] = 32'hC0DE_0000 + 32'(p * 64 + i);
      run(1'b1, p, b, 1'b1, 1'b0);
      @(negedge clk);
      for (int i = 0; i < 16; i++) if (mem[{b[7:4], 4'(i)}] !== lbuf[i]) ok = 1'b0;
      chk(ok, "R5 hub block matches buffer", mem[{b[7:4], 4'd0}], lbuf[0]);
    end

    // R7: start while busy ignored
    for (int i = 0; i < 16; i++) lbuf[i] = 32'h0;
    run(1'b0, 6, 19'h00A20, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    chk(!busy && !hub_req, "R7 no extra burst", {30'b0, busy, hub_req}, 32'd0);

    // R8: chained start in the done cycle
    run(1'b0, 11, 19'h00B3C, 1'b1, 1'b0);
    run(1'b0, 0, 19'h00C01, 1'b0, 1'b0);
    @(negedge clk);
    chk(!busy && !done, "R8 chained burst finished", {30'b0, busy, done}, 32'd0);
    repeat (2) @(negedge clk);
    chk(expq.size() == 0, "R4 all expected writes seen", 32'(expq.size()), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule